// File: doc/BRIEF.md
# Memory ECC Checker with Diagnostic Paths

This block guards a small word memory with an 8-bit check byte per 32-bit data word. On a write it computes the check byte and stores it beside the data in a separate check array. On a read it recomputes the check byte and compares it with the stored one. It corrects any single-bit data error. It flags every double-bit error, and every three- or four-bit error whose bits fall in one 4-bit nibble, as uncorrectable. Sticky status bits record corrected and uncorrectable events until software clears them.

Three diagnostic features support bring-up of the check storage:
- A source select can store the low data byte as the check byte, so that chosen check values can be planted.
- A capture register shows the raw stored check byte of each read. The byte lands in the lane picked by the low address bits.
- Four force bits set a per-lane bus parity status at once, with no memory access.

A write-side flip mask corrupts the stored data after the check byte is generated, so that errors can be injected.

Top module: `ecc_guard_unit`

## Requirements
- R1: With `chk_src_sel` high, the stored check byte is computed from the written data. Bits 0..3 are the parity of the data ANDed with 32'h1111_1111 shifted left by 0..3. Bit 4 is the parity of data & 32'hF0F0_F0F0. Bit 5 is the parity of data & 32'hFF00_FF00. Bit 6 is the parity of data & 32'hFFFF_0000. Bit 7 is the parity of all 32 bits.
- R2: A read accepted on an edge with `rd_en` high gives `rd_valid` high for exactly one cycle, two edges later. For a clean word, `rd_data` equals the written data and `rd_corrected` and `rd_uncorr` are low.
- R3: With `corr_en` high, a read whose stored data differs from the written data in one bit returns the written data. It pulses `rd_corrected` and sets `sec_stat` on the same edge as `rd_valid`.
- R4: With `corr_en` high, any two-bit data error gives the stored data unmodified on `rd_data`. It pulses `rd_uncorr` and sets `mbe_stat`.
- R5: A three- or four-bit data error confined to one nibble (bits 4n..4n+3) is handled as in R4.
- R6: With `corr_en` low at the read, `rd_data` is the stored data unmodified. `rd_corrected` and `rd_uncorr` stay low, and `sec_stat` and `mbe_stat` do not change.
- R7: With `chk_src_sel` low, `wr_data[7:0]` is stored as the check byte and the data word is stored normally.
- R8: Each valid read loads the raw stored check byte into byte lane `addr[1:0]` of `chk_capture`, bits 8*lane+7..8*lane. The other lanes keep their value.
- R9: `force_perr[i]` high on an edge sets `perr_stat[i]` on that edge, with no read or write.
- R10: `clr_err` high on an edge clears `sec_stat`, `mbe_stat` and `perr_stat`. An event set on the same edge takes priority. Without `clr_err`, all three hold their set bits.
- R11: After reset, `rd_valid`, `rd_data`, the pulse outputs, all status bits and `chk_capture` are zero.
- R12: `wr_err_mask` is XORed into the stored data after the check byte is generated from the unflipped `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address for read or write |
| wr_data | input | DATA_W | Write data |
| wr_err_mask | input | DATA_W | Bits to flip in the stored data |
| chk_src_sel | input | 1 | 1: store the computed check byte; 0: store the low data byte |
| corr_en | input | 1 | Enable correction and status update for a read |
| force_perr | input | LANES | Force per-lane bus parity status |
| clr_err | input | 1 | Clear sticky status |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read data, corrected when possible |
| rd_corrected | output | 1 | This read had a corrected single-bit error |
| rd_uncorr | output | 1 | This read had an uncorrectable error |
| sec_stat | output | 1 | Sticky single-error-corrected status |
| mbe_stat | output | 1 | Sticky multi-bit-error status |
| perr_stat | output | LANES | Sticky per-lane parity status |
| chk_capture | output | LANES*CHK_W | Raw stored check bytes, one lane per low address value |

## Verification
The assertions take for granted that `rd_en` and `wr_en` are never high in the same cycle. They also take for granted that `corr_en` and `addr` are held for the cycle of the read strobe. The bench drives one operation at a time, on the falling edge, and releases each strobe after one cycle. It reads only addresses it has written, so the check array never returns uninitialised contents. Error patterns are confined to the fault classes the code guarantees: all single bits, all pairs, and all nibble-local triples and quads.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_FIXED = 2'd1,
    SYN_BAD   = 2'd2
  } syn_kind_e;

  // Column of the check matrix for one data bit. The low four bits hold a
  // one-hot position inside the nibble. The next idx_w bits hold the nibble
  // index. The top bit covers every data bit (overall parity).
  function automatic logic [31:0] ecc_column(input int bit_idx, input int idx_w);
    logic [31:0] c;
    c = 32'(1) << (bit_idx % 4);
    c = c | (32'(bit_idx / 4) << 4);
    c = c | (32'(1) << (4 + idx_w));
    return c;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  localparam int IDX_W = CHK_W - 5;

  always_comb begin
    chk = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (data[i]) chk = chk ^ CHK_W'(ecc_column(i, IDX_W));
    end
  end
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import ecc_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8
) (
  input  logic [DATA_W-1:0] data_raw,
  input  logic [CHK_W-1:0]  chk_raw,
  output logic [DATA_W-1:0] data_fix,
  output syn_kind_e         kind
);
  localparam int IDX_W = CHK_W - 5;

  logic [CHK_W-1:0]  chk_calc;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] hit;

  ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recalc (
    .data (data_raw),
    .chk  (chk_calc)
  );

  assign syn = chk_calc ^ chk_raw;

  for (genvar g = 0; g < DATA_W; g++) begin : g_hit
    assign hit[g] = (syn == CHK_W'(ecc_column(g, IDX_W)));
  end

  assign data_fix = data_raw ^ hit;

  always_comb begin
    if (syn == '0)  kind = SYN_CLEAN;
    else if (|hit)  kind = SYN_FIXED;
    else            kind = SYN_BAD;
  end
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [CHK_W-1:0]  wr_chk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic [CHK_W-1:0]  rd_chk
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [CHK_W-1:0]  chk_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_addr] <= wr_word;
      chk_mem[wr_addr]  <= wr_chk;
    end
    if (rd_en) begin
      rd_word <= data_mem[rd_addr];
      rd_chk  <= chk_mem[rd_addr];
    end
  end
endmodule

// File: rtl/ecc_status_regs.sv
module ecc_status_regs #(
  parameter int CHK_W  = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   res_valid,
  input  logic [LANE_W-1:0]      lane,
  input  logic [CHK_W-1:0]       raw_chk,
  input  logic                   ev_sec,
  input  logic                   ev_mbe,
  input  logic [LANES-1:0]       force_perr,
  input  logic                   clr_err,
  output logic                   sec_stat,
  output logic                   mbe_stat,
  output logic [LANES-1:0]       perr_stat,
  output logic [LANES*CHK_W-1:0] capture
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_stat  <= 1'b0;
      mbe_stat  <= 1'b0;
      perr_stat <= '0;
    end else begin
      sec_stat  <= (sec_stat & ~clr_err) | ev_sec;
      mbe_stat  <= (mbe_stat & ~clr_err) | ev_mbe;
      perr_stat <= (perr_stat & {LANES{~clr_err}}) | force_perr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capture <= '0;
    end else if (res_valid) begin
      capture[lane*CHK_W +: CHK_W] <= raw_chk;
    end
  end
endmodule

// File: rtl/ecc_guard_unit.sv
module ecc_guard_unit
  import ecc_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [DATA_W-1:0]      wr_err_mask,
  input  logic                   chk_src_sel,
  input  logic                   corr_en,
  input  logic [LANES-1:0]       force_perr,
  input  logic                   clr_err,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_corrected,
  output logic                   rd_uncorr,
  output logic                   sec_stat,
  output logic                   mbe_stat,
  output logic [LANES-1:0]       perr_stat,
  output logic [LANES*CHK_W-1:0] chk_capture
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  // Write side
  logic [CHK_W-1:0]  enc_chk;
  logic [CHK_W-1:0]  store_chk;
  logic [DATA_W-1:0] store_word;

  ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data (wr_data),
    .chk  (enc_chk)
  );

  assign store_chk  = chk_src_sel ? enc_chk : wr_data[CHK_W-1:0];
  assign store_word = wr_data ^ wr_err_mask;

  // Storage, one read stage
  logic [DATA_W-1:0] mem_word;
  logic [CHK_W-1:0]  mem_chk;

  ecc_word_store #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_word (store_word),
    .wr_chk  (store_chk),
    .rd_en   (rd_en),
    .rd_addr (addr),
    .rd_word (mem_word),
    .rd_chk  (mem_chk)
  );

  logic              p1_rd;
  logic              p1_corr;
  logic [LANE_W-1:0] p1_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_rd   <= 1'b0;
      p1_corr <= 1'b0;
      p1_lane <= '0;
    end else begin
      p1_rd <= rd_en;
      if (rd_en) begin
        p1_corr <= corr_en;
        p1_lane <= addr[LANE_W-1:0];
      end
    end
  end

  // Decode stage
  logic [DATA_W-1:0] fix_word;
  syn_kind_e         kind;
  logic              ev_sec;
  logic              ev_mbe;

  ecc_syndrome_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
    .data_raw (mem_word),
    .chk_raw  (mem_chk),
    .data_fix (fix_word),
    .kind     (kind)
  );

  assign ev_sec = p1_rd & p1_corr & (kind == SYN_FIXED);
  assign ev_mbe = p1_rd & p1_corr & (kind == SYN_BAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rd_corrected <= 1'b0;
      rd_uncorr    <= 1'b0;
    end else begin
      rd_valid     <= p1_rd;
      rd_corrected <= ev_sec;
      rd_uncorr    <= ev_mbe;
      if (p1_rd) rd_data <= ev_sec ? fix_word : mem_word;
    end
  end

  ecc_status_regs #(.CHK_W(CHK_W), .LANES(LANES), .LANE_W(LANE_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .res_valid  (p1_rd),
    .lane       (p1_lane),
    .raw_chk    (mem_chk),
    .ev_sec     (ev_sec),
    .ev_mbe     (ev_mbe),
    .force_perr (force_perr),
    .clr_err    (clr_err),
    .sec_stat   (sec_stat),
    .mbe_stat   (mbe_stat),
    .perr_stat  (perr_stat),
    .capture    (chk_capture)
  );
endmodule

// File: rtl/ecc_guard_chk.sv
module ecc_guard_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             rd_corrected,
  input logic             rd_uncorr,
  input logic             sec_stat,
  input logic             mbe_stat,
  input logic [LANES-1:0] force_perr,
  input logic [LANES-1:0] perr_stat,
  input logic             clr_err
);
  // Input assumption for R2: one operation per cycle
  a_r2_single_op: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 rd_valid);

  a_r2_valid_has_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en, 2));

  a_r3_fix_sets_status: assert property (@(posedge clk) disable iff (rst)
    rd_corrected |-> sec_stat);

  a_r4_bad_sets_status: assert property (@(posedge clk) disable iff (rst)
    rd_uncorr |-> mbe_stat);

  a_r3_kind_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_corrected && rd_uncorr));

  a_r6_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_corrected || rd_uncorr) |-> rd_valid);

  a_r9_force_sets: assert property (@(posedge clk) disable iff (rst)
    (|force_perr) |=> ((perr_stat & $past(force_perr)) == $past(force_perr)));

  a_r10_perr_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_err |=> ((perr_stat & $past(perr_stat)) == $past(perr_stat)));

  a_r10_sec_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr_err && sec_stat) |=> sec_stat);

  a_r10_mbe_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr_err && mbe_stat) |=> mbe_stat);
endmodule

bind ecc_guard_unit ecc_guard_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .rd_valid     (rd_valid),
  .rd_corrected (rd_corrected),
  .rd_uncorr    (rd_uncorr),
  .sec_stat     (sec_stat),
  .mbe_stat     (mbe_stat),
  .force_perr   (force_perr),
  .perr_stat    (perr_stat),
  .clr_err      (clr_err)
);

// File: tb/tb_ecc_guard_unit.sv
module tb_ecc_guard_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0, wr_err_mask = '0;
  logic        chk_src_sel = 1'b1, corr_en = 1'b1;
  logic [3:0]  force_perr = '0;
  logic        clr_err = 1'b0;
  logic        rd_valid, rd_corrected, rd_uncorr, sec_stat, mbe_stat;
  logic [31:0] rd_data;
  logic [3:0]  perr_stat;
  logic [31:0] chk_capture;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] cap_model = '0;

  always #5 clk = ~clk;

  ecc_guard_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .wr_err_mask(wr_err_mask), .chk_src_sel(chk_src_sel),
    .corr_en(corr_en), .force_perr(force_perr), .clr_err(clr_err),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_corrected(rd_corrected),
    .rd_uncorr(rd_uncorr), .sec_stat(sec_stat), .mbe_stat(mbe_stat),
    .perr_stat(perr_stat), .chk_capture(chk_capture)
  );

  function automatic logic [7:0] exp_chk(input logic [31:0] d);
    logic [7:0] c;
    for (int p = 0; p < 4; p++) c[p] = ^(d & (32'h1111_1111 << p));
    c[4] = ^(d & 32'hF0F0_F0F0);
    c[5] = ^(d & 32'hFF00_FF00);
    c[6] = ^(d & 32'hFFFF_0000);
    c[7] = ^d;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [31:0] m, input logic sel);
    @(negedge clk);
    addr = a; wr_data = d; wr_err_mask = m; chk_src_sel = sel; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_err_mask = '0; chk_src_sel = 1'b1;
  endtask

  // Returns after the result edge; outputs are sampled on the falling edge.
  task automatic do_read(input logic [3:0] a, input logic ce, input logic [7:0] stored_chk);
    @(negedge clk);
    addr = a; corr_en = ce; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    cap_model[a[1:0]*8 +: 8] = stored_chk;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    logic [31:0] d, m;
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hA5C3_0F96;
    pats[2] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(rd_valid == 0 && rd_data == 0 && rd_corrected == 0 && rd_uncorr == 0,
          "R11 read outputs after reset", {rd_valid, rd_corrected, rd_uncorr, rd_data}, 0);
    check(sec_stat == 0 && mbe_stat == 0 && perr_stat == 0 && chk_capture == 0,
          "R11 status after reset", {sec_stat, mbe_stat, perr_stat, chk_capture}, 0);

    // R1, R2, R8: clean words on several addresses
    for (int i = 0; i < 8; i++) begin
      d = 32'h9E37_79B9 * (i + 1) ^ (32'h1 << (i * 4));
      do_write(4'(i), d, '0, 1'b1);
      do_read(4'(i), 1'b1, exp_chk(d));
      check(rd_valid == 1, "R2 valid two edges after read", rd_valid, 1);
      check(rd_data == d && !rd_corrected && !rd_uncorr, "R2 clean read",
            {rd_corrected, rd_uncorr, rd_data}, {2'b00, d});
      check(chk_capture[(i % 4) * 8 +: 8] == exp_chk(d), "R1 stored check byte",
            chk_capture[(i % 4) * 8 +: 8], exp_chk(d));
      check(chk_capture == cap_model, "R8 capture lanes", chk_capture, cap_model);
    end
    @(negedge clk);
    check(rd_valid == 0, "R2 valid lasts one cycle", rd_valid, 0);

    // R7: low data byte stored as check byte
    d = 32'hCAFE_F00D;
    do_write(4'd9, d, '0, 1'b0);
    do_read(4'd9, 1'b0, d[7:0]);
    check(chk_capture[15:8] == 8'h0D, "R7 low byte as check", chk_capture[15:8], 8'h0D);
    check(rd_data == d, "R7 data stored normally", rd_data, d);
    check(chk_capture == cap_model, "R8 other lanes held", chk_capture, cap_model);

    // R6: correction disabled passes a single error raw, no status
    d = 32'h1357_9BDF;
    do_write(4'd2, d, 32'h0000_0400, 1'b1);
    do_read(4'd2, 1'b0, exp_chk(d));
    check(rd_data == (d ^ 32'h400) && !rd_corrected && !rd_uncorr, "R6 raw data when disabled",
          {rd_corrected, rd_uncorr, rd_data}, {2'b00, d ^ 32'h400});
    check(sec_stat == 0 && mbe_stat == 0, "R6 status unchanged", {sec_stat, mbe_stat}, 0);

    // R3, R12: every single-bit data error on three patterns
    for (int p = 0; p < 3; p++) begin
      for (int b = 0; b < 32; b++) begin
        m = 32'h1 << b;
        do_write(4'd3, pats[p], m, 1'b1);
        do_read(4'd3, 1'b1, exp_chk(pats[p]));
        check(rd_data == pats[p] && rd_corrected && !rd_uncorr, "R3 single-bit correction",
              {rd_corrected, rd_uncorr, rd_data}, {2'b10, pats[p]});
        check(chk_capture[31:24] == exp_chk(pats[p]), "R12 check from unflipped data",
              chk_capture[31:24], exp_chk(pats[p]));
      end
    end
    check(sec_stat == 1 && mbe_stat == 0, "R3 sticky single status", {sec_stat, mbe_stat}, 2'b10);
    pulse_clear();
    check(sec_stat == 0, "R10 clear single status", sec_stat, 0);

    // R4: every two-bit error
    d = 32'h1234_5678;
    for (int a = 0; a < 32; a++) begin
      for (int b = a + 1; b < 32; b++) begin
        m = (32'h1 << a) | (32'h1 << b);
        do_write(4'd5, d, m, 1'b1);
        do_read(4'd5, 1'b1, exp_chk(d));
        check(rd_data == (d ^ m) && rd_uncorr && !rd_corrected, "R4 double error flagged",
              {rd_corrected, rd_uncorr, rd_data}, {2'b01, d ^ m});
      end
    end
    check(mbe_stat == 1 && sec_stat == 0, "R4 sticky multi status", {sec_stat, mbe_stat}, 2'b01);
    pulse_clear();
    check(mbe_stat == 0, "R10 clear multi status", mbe_stat, 0);

    // R5: three- and four-bit errors inside one nibble
    d = 32'h0F1E_2D3C;
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 5; k++) begin
        m = (k < 4) ? (32'(4'hF & ~(4'h1 << k)) << (4 * n)) : (32'hF << (4 * n));
        do_write(4'd6, d, m, 1'b1);
        do_read(4'd6, 1'b1, exp_chk(d));
        check(rd_data == (d ^ m) && rd_uncorr && !rd_corrected, "R5 nibble error flagged",
              {rd_corrected, rd_uncorr, rd_data}, {2'b01, d ^ m});
      end
    end
    pulse_clear();

    // R9: forced parity status per lane, no access
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); force_perr = 4'(1 << i);
      @(negedge clk); force_perr = '0;
      check(perr_stat[i] == 1, "R9 forced lane status", perr_stat, 4'(1 << i));
      check(sec_stat == 0 && mbe_stat == 0 && rd_valid == 0, "R9 no read side effect",
            {sec_stat, mbe_stat, rd_valid}, 0);
    end
    check(perr_stat == 4'hF, "R10 parity status sticky", perr_stat, 4'hF);
    pulse_clear();
    check(perr_stat == 0, "R10 clear parity status", perr_stat, 0);
    @(negedge clk); force_perr = 4'b0100; clr_err = 1'b1;
    @(negedge clk); force_perr = '0; clr_err = 1'b0;
    check(perr_stat == 4'b0100, "R10 event wins over clear", perr_stat, 4'b0100);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule